// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block caches a 256-byte, byte-addressed memory space in 64 bytes of local storage. The storage is arranged as four sets of two ways, and each way holds one 8-byte block. A byte address is split into a 3-bit tag in the top bits, a 2-bit set index and a 3-bit byte offset in the bottom bits. Each way's entry holds a valid flag, a modified flag and the stored tag. Each set also keeps one recency bit that names its least recently used way.

The CPU side is a valid/ready request stream that carries a read or write strobe, an address and a write byte. Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. After a request is taken, `req_ready` stays low until its single response cycle, marked by `rsp_valid`. There is no ready on the response, so the requester must take it in that cycle.

Lookups compare both ways of the set in parallel. A hit finishes in the cycle after acceptance. A miss picks a victim way. If that victim holds modified data, its whole block is first written back through a block-wide request/acknowledge port. The missing block is then read in and installed, and the lookup is repeated. A write miss is therefore handled as a fill followed by a write hit, and only the cache copy is changed.

Top module: `c2w_cache`

## Requirements
- R1: The address splits as tag = addr[7:5], set = addr[4:3], byte offset = addr[2:0]. A read of a resident block returns the byte at that offset, and `rsp_hit` is 1.
- R2: Two blocks that map to the same set can be resident together. After both are loaded, alternating reads of the two blocks all hit, and no memory request is made.
- R3: On a miss where the set still has an invalid way, the new block goes into an invalid way. No block is evicted, nothing is written back, and the response has `rsp_hit` = 0.
- R4: On a miss where both ways are valid, the least recently used way is replaced. Every hit and every fill marks the accessed way as most recently used.
- R5: A write hit changes only the cached byte and marks the block modified. It causes no memory request, and a later read returns the new byte.
- R6: When the victim is modified, its full block is written to memory at block address {victim tag, set} before the fill read starts. A clean victim causes no memory write. `mem_wdata` and `mem_rdata` carry byte i of the block in bits [8i+7:8i].
- R7: A write miss reads the whole block at block address {tag, set}, installs it, and then writes the byte. The response reports `rsp_hit` = 0. The other bytes of the block then read back the memory values.
- R8: After reset all ways are invalid, `req_ready` is 1 and `mem_req` is 0, and the first access to any block misses.
- R9: `req_ready` is low from the acceptance of a request until its response cycle. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response cycle |
| rsp_hit | output | 1 | 1 when the request hit on first lookup |
| rsp_rdata | output | 8 | Read byte (meaningful for reads) |
| mem_req | output | 1 | Memory block request, held until acknowledged |
| mem_we | output | 1 | 1 = write back, 0 = fill read |
| mem_addr | output | 5 | Block address {tag, set} |
| mem_wdata | output | 64 | Block written back |
| mem_ack | input | 1 | Memory done; carries read block for fills |
| mem_rdata | input | 64 | Block returned on a fill acknowledge |

## Verification
The bench targets the same-set pattern A, B, A, B. A direct-mapped or single-way mistake would show it as a string of misses. It then adds a third block, which exposes a wrong recency choice: the design would evict the block just touched and miss on the next access to it. Dirty eviction is checked byte for byte against a behavioural memory, so a lost write-back or a stale block shows up as wrong memory contents at the end. A write-back of a clean block shows up as an unexpected memory write. Write misses are checked to fetch first and merge the byte after, so a design that skipped the fill would return wrong neighbouring bytes. Random latencies on the memory side stress the hold rules of the request port.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_EVICT  = 2'd2,
    ST_FILL   = 2'd3
  } c2w_state_e;

  function automatic int unsigned lane_lsb(input int unsigned off);
    return off * 8;
  endfunction
endpackage

// File: rtl/c2w_tag_store.sv
module c2w_tag_store #(
  parameter int TAG_W = 3,
  parameter int IDX_W = 2,
  parameter int WAYS  = 2,
  localparam int SETS  = 1 << IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             valid_vec,
  output logic [WAYS-1:0]             dirty_vec,
  output logic [WAYS-1:0][TAG_W-1:0]  tags,
  output logic [WAY_W-1:0]            lru_way,
  input  logic                        install_en,
  input  logic [WAY_W-1:0]            install_way,
  input  logic                        dirty_en,
  input  logic [WAY_W-1:0]            dirty_way,
  input  logic                        touch_en,
  input  logic [WAY_W-1:0]            touch_way
);
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAY_W-1:0]           lru_q   [SETS];

  assign valid_vec = valid_q[idx];
  assign dirty_vec = dirty_q[idx];
  assign tags      = tag_q[idx];
  assign lru_way   = lru_q[idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == lk_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        tag_q[s]   <= '0;
        lru_q[s]   <= '0;
      end
    end else begin
      if (install_en) begin
        valid_q[idx][install_way] <= 1'b1;
        dirty_q[idx][install_way] <= 1'b0;
        tag_q[idx][install_way]   <= lk_tag;
      end
      if (dirty_en) dirty_q[idx][dirty_way] <= 1'b1;
      if (touch_en) lru_q[idx] <= ~touch_way;
    end
  end

  // R2
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/c2w_data_store.sv
module c2w_data_store #(
  parameter int IDX_W = 2,
  parameter int OFF_W = 3,
  parameter int WAYS  = 2,
  localparam int SETS  = 1 << IDX_W,
  localparam int BLK_W = 8 << OFF_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte,
  output logic [BLK_W-1:0] rd_block,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [BLK_W-1:0] fill_data,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_byte
);
  import c2w_pkg::*;

  logic [BLK_W-1:0] blk_q [WAYS][SETS];

  assign rd_block = blk_q[rd_way][idx];
  assign rd_byte  = rd_block[lane_lsb(rd_off) +: 8];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (fill_en && (fill_way == WAY_W'(w)))
        blk_q[w][idx] <= fill_data;
      else if (wr_en && (wr_way == WAY_W'(w)))
        blk_q[w][idx][lane_lsb(wr_off) +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/c2w_victim_sel.sv
module c2w_victim_sel #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim
);
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = lru_way;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_vec[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache #(
  parameter int TAG_W = 3,
  parameter int IDX_W = 2,
  parameter int OFF_W = 3,
  localparam int WAYS       = 2,
  localparam int WAY_W      = 1,
  localparam int ADDR_W     = TAG_W + IDX_W + OFF_W,
  localparam int BLK_ADDR_W = TAG_W + IDX_W,
  localparam int BLK_W      = 8 << OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [7:0]            req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [7:0]            rsp_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [BLK_ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]      mem_wdata,
  input  logic                  mem_ack,
  input  logic [BLK_W-1:0]      mem_rdata
);
  import c2w_pkg::*;

  c2w_state_e        state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic              missed_q;
  logic [WAY_W-1:0]  victim_q;

  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFF_W-1:0] a_off;
  assign a_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign a_idx = addr_q[OFF_W +: IDX_W];
  assign a_off = addr_q[OFF_W-1:0];

  logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0] tags;
  logic [WAY_W-1:0]           lru_way, victim, hit_way, rd_way;
  logic                       any_hit;
  logic                       install_en, dirty_en, touch_en, wr_en;
  logic [WAY_W-1:0]           touch_way;
  logic [BLK_W-1:0]           rd_block;
  logic [7:0]                 rd_byte;

  assign any_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  c2w_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(a_idx), .lk_tag(a_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .tags(tags), .lru_way(lru_way),
    .install_en(install_en), .install_way(victim_q),
    .dirty_en(dirty_en), .dirty_way(hit_way),
    .touch_en(touch_en), .touch_way(touch_way)
  );

  c2w_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid_vec(valid_vec), .lru_way(lru_way), .victim(victim)
  );

  assign rd_way = (state_q == ST_EVICT) ? victim_q : hit_way;

  c2w_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_data (
    .clk(clk), .idx(a_idx), .rd_way(rd_way), .rd_off(a_off),
    .rd_byte(rd_byte), .rd_block(rd_block),
    .fill_en(install_en), .fill_way(victim_q), .fill_data(mem_rdata),
    .wr_en(wr_en), .wr_way(hit_way), .wr_off(a_off), .wr_byte(wdata_q)
  );

  always_comb begin
    state_d    = state_q;
    req_ready  = 1'b0;
    rsp_valid  = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = {a_tag, a_idx};
    install_en = 1'b0;
    dirty_en   = 1'b0;
    touch_en   = 1'b0;
    touch_way  = hit_way;
    wr_en      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (any_hit) begin
          rsp_valid = 1'b1;
          touch_en  = 1'b1;
          wr_en     = we_q;
          dirty_en  = we_q;
          state_d   = ST_IDLE;
        end else if (valid_vec[victim] && dirty_vec[victim]) begin
          state_d = ST_EVICT;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_EVICT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {tags[victim_q], a_idx};
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          install_en = 1'b1;
          touch_en   = 1'b1;
          touch_way  = victim_q;
          state_d    = ST_LOOKUP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_wdata = rd_block;
  assign rsp_hit   = !missed_q;
  assign rsp_rdata = rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      missed_q <= 1'b0;
      victim_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        we_q     <= req_we;
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        missed_q <= 1'b0;
      end
      if (state_q == ST_LOOKUP && !any_hit) begin
        missed_q <= 1'b1;
        victim_q <= victim;
      end
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R9
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R3
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOKUP && !any_hit && !(&valid_vec)) |-> !valid_vec[victim]);

  // R6
  wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (valid_vec[victim_q] && dirty_vec[victim_q]));

  // R7
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && mem_ack) |=> (state_q == ST_LOOKUP && any_hit));

  // R5
  write_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && we_q) |=> (|(hit_vec & dirty_vec)));
endmodule

// File: tb/c2w_cache_tb.sv
`timescale 1ns/1ps
module c2w_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [7:0]  req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [7:0]  rsp_rdata;
  logic        mem_req, mem_we;
  logic [4:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  c2w_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit timeout = 0;

  logic [7:0] truth   [256];
  logic [7:0] backing [256];
  int  mru_tag [4];
  int  lru_tag [4];
  bit  dirtyb  [32];
  int  exp_wb, exp_fill;
  bit  wb_seen, fill_seen;
  string cur_tag;

  task automatic chk(input bit ok, input string tg, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !timeout) timeout = 1;
  end

  // memory responder with random latency
  initial begin
    int lat = 1;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          if (mem_we) begin
            chk(int'(mem_addr) == exp_wb, "R6", "writeback block address", int'(mem_addr), exp_wb);
            for (int i = 0; i < 8; i++) begin
              chk(mem_wdata[8*i +: 8] == truth[{mem_addr, 3'(i)}], "R6", "writeback byte",
                  int'(mem_wdata[8*i +: 8]), int'(truth[{mem_addr, 3'(i)}]));
              backing[{mem_addr, 3'(i)}] = mem_wdata[8*i +: 8];
            end
            chk(!fill_seen, "R6", "writeback after fill", int'(fill_seen), 0);
            wb_seen = 1;
          end else begin
            chk(int'(mem_addr) == exp_fill, cur_tag, "fill block address", int'(mem_addr), exp_fill);
            for (int i = 0; i < 8; i++) mem_rdata[8*i +: 8] = backing[{mem_addr, 3'(i)}];
            fill_seen = 1;
          end
          mem_ack = 1'b1;
          lat = $urandom_range(0, 3);
        end
      end
    end
  end

  task automatic do_access(input bit we, input logic [7:0] a, input logic [7:0] d,
                           input string tg);
    int blk, st, tg3, victim;
    bit exp_hit, ready_bad;
    logic [7:0] exp_rd;
    blk = int'(a[7:3]); st = blk & 3; tg3 = blk >> 2;
    exp_wb = -1; exp_fill = -1; wb_seen = 0; fill_seen = 0; cur_tag = tg;
    exp_rd = truth[a];
    if (mru_tag[st] == tg3) exp_hit = 1;
    else if (lru_tag[st] == tg3) begin
      exp_hit = 1; lru_tag[st] = mru_tag[st]; mru_tag[st] = tg3;
    end else begin
      exp_hit = 0; exp_fill = blk;
      if (lru_tag[st] >= 0) begin
        victim = (lru_tag[st] << 2) | st;
        if (dirtyb[victim]) exp_wb = victim;
        dirtyb[victim] = 0;
      end
      lru_tag[st] = mru_tag[st]; mru_tag[st] = tg3;
      dirtyb[blk] = 0;
    end
    if (we) begin dirtyb[blk] = 1; truth[a] = d; end

    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!timeout && !req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ready_bad = 0;
    while (!timeout && !rsp_valid) begin
      if (req_ready) ready_bad = 1;
      @(negedge clk);
    end
    if (timeout) return;
    chk(!ready_bad && !req_ready, "R9", "ready while busy", int'(ready_bad), 0);
    chk(rsp_hit == exp_hit, tg, "hit flag", int'(rsp_hit), int'(exp_hit));
    if (!we) chk(rsp_rdata == exp_rd, tg, "read data", int'(rsp_rdata), int'(exp_rd));
    chk(wb_seen == (exp_wb >= 0), "R6", "writeback occurred", int'(wb_seen), int'(exp_wb >= 0));
    chk(fill_seen == !exp_hit, tg, "fill occurred", int'(fill_seen), int'(!exp_hit));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      truth[i] = 8'(i * 7 + 3);
      backing[i] = truth[i];
    end
    for (int s = 0; s < 4; s++) begin mru_tag[s] = -1; lru_tag[s] = -1; end
    for (int b = 0; b < 32; b++) dirtyb[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(req_ready == 1'b1, "R8", "req_ready after reset", int'(req_ready), 1);
    chk(mem_req == 1'b0, "R8", "mem_req after reset", int'(mem_req), 0);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", int'(rsp_valid), 0);

    // same-set pair A=0x00, B=0x40, third block C=0x20 (all set 0)
    do_access(0, 8'h00, 0, "R8");
    do_access(0, 8'h40, 0, "R3");
    do_access(0, 8'h00, 0, "R2");
    do_access(0, 8'h40, 0, "R2");
    do_access(0, 8'h05, 0, "R1");
    do_access(0, 8'h20, 0, "R4");   // evicts B
    do_access(0, 8'h02, 0, "R4");   // A still resident
    do_access(0, 8'h41, 0, "R4");   // evicts C
    do_access(1, 8'h01, 8'hA5, "R5");
    do_access(0, 8'h01, 0, "R5");
    do_access(0, 8'h23, 0, "R6");   // evicts clean B
    do_access(0, 8'h44, 0, "R6");   // evicts dirty A
    do_access(1, 8'h9B, 8'h3C, "R7");
    do_access(0, 8'h98, 0, "R7");
    do_access(0, 8'h9B, 0, "R7");
    do_access(1, 8'hDB, 8'h77, "R7"); // set 3 second way
    do_access(1, 8'h1B, 8'h11, "R7"); // evicts dirty 0x98 block

    for (int n = 0; n < 3000 && !timeout; n++) begin
      logic [7:0] ra;
      ra = {$urandom_range(0, 7) > 5 ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 2)),
            2'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
      do_access($urandom_range(0, 2) == 0, ra, 8'($urandom_range(0, 255)), "R1");
    end

    // memory contents: every block not held modified must match
    for (int b = 0; b < 32; b++) begin
      int st, t;
      bit res, same;
      st = b & 3; t = b >> 2;
      res = (mru_tag[st] == t) || (lru_tag[st] == t);
      if (!(res && dirtyb[b])) begin
        same = 1;
        for (int i = 0; i < 8; i++) if (backing[b*8+i] != truth[b*8+i]) same = 0;
        chk(same, "R6", "memory block contents", int'(same), 1);
      end
    end

    if (timeout) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule